// File: doc/BRIEF.md
# Pipeline Data-Hazard Unit with Selectable Policy

This block finds read-after-write conflicts in a five-stage in-order integer pipeline. The five stages are fetch, decode, execute, memory and writeback. Each cycle it compares the source registers of two instructions against the destination registers of the older instructions in flight. The instruction in decode is compared against execute and memory. The instruction in execute is compared against memory and writeback. It then drives the operand-select controls of the execute-stage ALU multiplexers, a hold signal for the fetch and decode registers, and a bubble-insert signal for execute.

The protection policy is chosen at run time through a two-bit mode input, which offers three policies:
- **Full forwarding.** Results are routed from the memory stage or the writeback stage. The only stall left is the one after a load.
- **Stall-only interlock.** The dependent instruction is held until its producer has reached writeback. At that point the register file's same-cycle write-through supplies the value.
- **No protection.** Stale operands are let through on purpose.

The mode is captured into an internal register only on clock edges where reset is active or the pipeline is idle. Idle means no stage holds a valid instruction. The surrounding core owns the pipeline registers and feeds the per-stage fields to this block each cycle.

Top module: `hz_hazard_unit`

## Requirements
- R1: In forwarding mode (mode code 2'b10), an execute source that is used, non-zero, and equal to the destination of a valid, write-enabled memory-stage instruction gives select code 2'b01 (memory result) on its operand select.
- R2: In forwarding mode, an execute source that matches only a valid, write-enabled writeback-stage destination gives select code 2'b10 (writeback result). With no match the code is 2'b00 (register file).
- R3: In forwarding mode, when both the memory and the writeback destinations match an execute source, the memory stage wins and the select is 2'b01.
- R4: Register index 0 never causes a forward or a stall, whatever the destinations hold.
- R5: A source whose use flag is low never causes a forward or a stall.
- R6: In forwarding mode, a decode source that matches the destination of a load in execute raises the stall and bubble outputs. A non-load producer in execute does not. After the one-cycle hold the consumer is served from writeback (select 2'b10).
- R7: In interlock mode (mode code 2'b01), a decode source that matches a live destination in execute or memory raises the stall and bubble outputs, and both operand selects stay 2'b00. A directly adjacent consumer is therefore held two cycles, and a consumer two slots behind is held one cycle.
- R8: In interlock mode, a match against the writeback destination alone raises no stall.
- R9: In no-protection mode (mode code 2'b00), the stall and bubble outputs stay low and both selects stay 2'b00 for every input pattern.
- R10: The mode takes effect only through clock edges during reset or while all four stage-valid inputs are low. A change of the mode input while any stage is valid does not alter behaviour.
- R11: A stage whose valid flag or write-enable is low takes no part in matching.
- R12: The unused mode code 2'b11 behaves as interlock mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; mode is sampled while low |
| modeSel | input | 2 | Policy: 00 none, 01 interlock, 10 forwarding, 11 as interlock |
| decValid | input | 1 | Decode stage holds an instruction |
| decRs1 | input | REG_AW | Decode first source index |
| decRs2 | input | REG_AW | Decode second source index |
| decUse1 | input | 1 | Decode reads its first source |
| decUse2 | input | 1 | Decode reads its second source |
| exValid | input | 1 | Execute stage holds an instruction |
| exRs1 | input | REG_AW | Execute first source index |
| exRs2 | input | REG_AW | Execute second source index |
| exUse1 | input | 1 | Execute reads its first source |
| exUse2 | input | 1 | Execute reads its second source |
| exRd | input | REG_AW | Execute destination index |
| exWrite | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memValid | input | 1 | Memory stage holds an instruction |
| memRd | input | REG_AW | Memory destination index |
| memWrite | input | 1 | Memory instruction writes a register |
| wbValid | input | 1 | Writeback stage holds an instruction |
| wbRd | input | REG_AW | Writeback destination index |
| wbWrite | input | 1 | Writeback instruction writes a register |
| fwdSelA | output | 2 | First ALU operand select: 00 regfile, 01 memory, 10 writeback |
| fwdSelB | output | 2 | Second ALU operand select, same coding |
| stallFetch | output | 1 | Hold the fetch and decode registers |
| bubbleEx | output | 1 | Load a bubble into execute |

## Verification
The bench builds the block with the default 5-bit register index, so all 32 architectural registers can be addressed. This gives room to mix index 0 with ordinary registers, and to use several distinct producer/consumer pairs in one scenario. Multi-cycle scenarios walk a producer through execute, memory and writeback by hand. This shows the two-cycle and one-cycle holds of the interlock policy and the single load-use hold of the forwarding policy. Mode switches are tried both while busy and while idle, to show when the mode register captures a new value.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_STALL = 2'b01,
    MODE_FWD   = 2'b10,
    MODE_RSVD  = 2'b11
  } hz_mode_e;

  typedef enum logic [1:0] {
    SEL_REG = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } hz_sel_e;

  // Strobes from the policy control into the match datapath.
  typedef struct packed {
    logic fwdEn;         // route memory/writeback results into execute
    logic holdOnEx;      // hold on any execute-stage producer
    logic holdOnLoadEx;  // hold only on a load in execute
    logic holdOnMem;     // hold on a memory-stage producer
  } hz_strobe_t;

  localparam int NUM_SRC = 2;

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] srcIdx,
  input  logic              srcUsed,
  input  logic [REG_AW-1:0] prodARd,
  input  logic              prodALive,
  input  logic [REG_AW-1:0] prodBRd,
  input  logic              prodBLive,
  output logic              hitA,
  output logic              hitB
);
  logic srcLive;

  assign srcLive = srcUsed && (srcIdx != '0);
  assign hitA    = srcLive && prodALive && (srcIdx == prodARd);
  assign hitB    = srcLive && prodBLive && (srcIdx == prodBRd);
endmodule

// File: rtl/hz_policy_ctrl.sv
module hz_policy_ctrl
  import hz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] modeSel,
  input  logic       idle,
  output hz_strobe_t strobe
);
  hz_mode_e modeQ;

  // Mode register: loads only under reset or while no stage is busy.
  always_ff @(posedge clk) begin
    if (!rst_n || idle) modeQ <= hz_mode_e'(modeSel);
  end

  always_comb begin
    strobe = '0;
    unique case (modeQ)
      MODE_OFF: strobe = '0;
      MODE_FWD: begin
        strobe.fwdEn        = 1'b1;
        strobe.holdOnLoadEx = 1'b1;
      end
      default: begin
        strobe.holdOnEx  = 1'b1;
        strobe.holdOnMem = 1'b1;
      end
    endcase
  end

  // R10: a busy pipeline keeps the captured policy
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(rst_n)) |=> $stable(modeQ));

  // R12: no policy both forwards and holds on memory-stage producers
  p_policy_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.fwdEn && (strobe.holdOnMem || strobe.holdOnEx)));
endmodule

// File: rtl/hz_match_path.sv
module hz_match_path
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hz_strobe_t        strobe,
  input  logic              decValid,
  input  logic [REG_AW-1:0] decRs1,
  input  logic [REG_AW-1:0] decRs2,
  input  logic              decUse1,
  input  logic              decUse2,
  input  logic              exValid,
  input  logic [REG_AW-1:0] exRs1,
  input  logic [REG_AW-1:0] exRs2,
  input  logic              exUse1,
  input  logic              exUse2,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exWrite,
  input  logic              exIsLoad,
  input  logic              memValid,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memWrite,
  input  logic              wbValid,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbWrite,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              stallFetch,
  output logic              bubbleEx
);
  logic [REG_AW-1:0] decSrc [NUM_SRC];
  logic [REG_AW-1:0] exSrc  [NUM_SRC];
  logic              decUse [NUM_SRC];
  logic              exUse  [NUM_SRC];
  hz_sel_e           fwdSel [NUM_SRC];
  logic [NUM_SRC-1:0] holdReq;
  logic exLive, memLive, wbLive, hazard;

  assign decSrc[0] = decRs1;  assign decSrc[1] = decRs2;
  assign exSrc[0]  = exRs1;   assign exSrc[1]  = exRs2;
  assign decUse[0] = decUse1; assign decUse[1] = decUse2;
  assign exUse[0]  = exUse1;  assign exUse[1]  = exUse2;

  // A producer counts only if valid, writing, and not targeting x0.
  assign exLive  = exValid  && exWrite  && (exRd  != '0);
  assign memLive = memValid && memWrite && (memRd != '0);
  assign wbLive  = wbValid  && wbWrite  && (wbRd  != '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic decHitEx, decHitMem, exHitMem, exHitWb;

    hz_src_cmp #(.REG_AW(REG_AW)) u_decCmp (
      .srcIdx(decSrc[i]), .srcUsed(decUse[i] && decValid),
      .prodARd(exRd), .prodALive(exLive),
      .prodBRd(memRd), .prodBLive(memLive),
      .hitA(decHitEx), .hitB(decHitMem));

    hz_src_cmp #(.REG_AW(REG_AW)) u_exCmp (
      .srcIdx(exSrc[i]), .srcUsed(exUse[i] && exValid),
      .prodARd(memRd), .prodALive(memLive),
      .prodBRd(wbRd), .prodBLive(wbLive),
      .hitA(exHitMem), .hitB(exHitWb));

    // Memory stage is the younger producer, so it is checked first.
    always_comb begin
      if (!strobe.fwdEn)  fwdSel[i] = SEL_REG;
      else if (exHitMem)  fwdSel[i] = SEL_MEM;
      else if (exHitWb)   fwdSel[i] = SEL_WB;
      else                fwdSel[i] = SEL_REG;
    end

    assign holdReq[i] = (strobe.holdOnEx  && decHitEx)
                     || (strobe.holdOnLoadEx && exIsLoad && decHitEx)
                     || (strobe.holdOnMem && decHitMem);
  end

  assign hazard     = |holdReq;
  assign fwdSelA    = fwdSel[0];
  assign fwdSelB    = fwdSel[1];
  assign stallFetch = hazard;
  assign bubbleEx   = hazard;

  // R4/R5: a forward needs a used, non-zero execute source
  p_fwd_needs_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwdSelA != SEL_REG) |-> (exUse1 && exRs1 != '0 && exValid));

  // R3: the memory stage wins when it matches
  p_mem_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fwdEn && exValid && exUse2 && exRs2 != '0 && memValid && memWrite
     && memRd == exRs2) |-> (fwdSelB == SEL_MEM));

  // R7/R9: no policy but forwarding moves the selects
  p_no_fwd_unless_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.fwdEn |-> (fwdSelA == SEL_REG && fwdSelB == SEL_REG));

  // R9: without hold strobes the pipeline never stops
  p_off_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.holdOnEx || strobe.holdOnLoadEx || strobe.holdOnMem) |-> !stallFetch);

  // R8: writeback alone never forces a hold
  p_wb_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!exValid && !memValid) |-> !stallFetch);
endmodule

// File: rtl/hz_hazard_unit.sv
module hz_hazard_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        modeSel,
  input  logic              decValid,
  input  logic [REG_AW-1:0] decRs1,
  input  logic [REG_AW-1:0] decRs2,
  input  logic              decUse1,
  input  logic              decUse2,
  input  logic              exValid,
  input  logic [REG_AW-1:0] exRs1,
  input  logic [REG_AW-1:0] exRs2,
  input  logic              exUse1,
  input  logic              exUse2,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exWrite,
  input  logic              exIsLoad,
  input  logic              memValid,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memWrite,
  input  logic              wbValid,
  input  logic [REG_AW-1:0] wbRd,
  input  logic              wbWrite,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              stallFetch,
  output logic              bubbleEx
);
  hz_strobe_t strobe;
  logic       idle;

  assign idle = !(decValid || exValid || memValid || wbValid);

  hz_policy_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .idle(idle), .strobe(strobe));

  hz_match_path #(.REG_AW(REG_AW)) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .decValid(decValid), .decRs1(decRs1), .decRs2(decRs2),
    .decUse1(decUse1), .decUse2(decUse2),
    .exValid(exValid), .exRs1(exRs1), .exRs2(exRs2),
    .exUse1(exUse1), .exUse2(exUse2),
    .exRd(exRd), .exWrite(exWrite), .exIsLoad(exIsLoad),
    .memValid(memValid), .memRd(memRd), .memWrite(memWrite),
    .wbValid(wbValid), .wbRd(wbRd), .wbWrite(wbWrite),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallFetch(stallFetch), .bubbleEx(bubbleEx));
endmodule

// File: tb/sim_hz_hazard_unit.sv
module sim_hz_hazard_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [1:0] mode;
    logic dv; logic [4:0] d1, d2; logic du1, du2;
    logic ev; logic [4:0] e1, e2; logic eu1, eu2; logic [4:0] erd; logic ew, el;
    logic mv; logic [4:0] mrd; logic mw;
    logic wv; logic [4:0] wrd; logic ww;
  } vec_t;

  typedef struct {
    logic [1:0] a, b;
    logic       st;
    string      req;
  } exp_t;

  vec_t v;
  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  logic [1:0] modeSel;
  logic decValid, decUse1, decUse2, exValid, exUse1, exUse2, exWrite, exIsLoad;
  logic memValid, memWrite, wbValid, wbWrite;
  logic [4:0] decRs1, decRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic [1:0] fwdSelA, fwdSelB;
  logic stallFetch, bubbleEx;

  hz_hazard_unit u0 (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel),
    .decValid(decValid), .decRs1(decRs1), .decRs2(decRs2),
    .decUse1(decUse1), .decUse2(decUse2),
    .exValid(exValid), .exRs1(exRs1), .exRs2(exRs2),
    .exUse1(exUse1), .exUse2(exUse2),
    .exRd(exRd), .exWrite(exWrite), .exIsLoad(exIsLoad),
    .memValid(memValid), .memRd(memRd), .memWrite(memWrite),
    .wbValid(wbValid), .wbRd(wbRd), .wbWrite(wbWrite),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stallFetch(stallFetch), .bubbleEx(bubbleEx));

  function automatic vec_t idleVec(input logic [1:0] m);
    vec_t r;
    r.mode = m;
    r.dv = 0; r.d1 = 0; r.d2 = 0; r.du1 = 0; r.du2 = 0;
    r.ev = 0; r.e1 = 0; r.e2 = 0; r.eu1 = 0; r.eu2 = 0; r.erd = 0; r.ew = 0; r.el = 0;
    r.mv = 0; r.mrd = 0; r.mw = 0;
    r.wv = 0; r.wrd = 0; r.ww = 0;
    return r;
  endfunction

  task automatic drive(input vec_t x);
    modeSel = x.mode;
    decValid = x.dv; decRs1 = x.d1; decRs2 = x.d2; decUse1 = x.du1; decUse2 = x.du2;
    exValid = x.ev; exRs1 = x.e1; exRs2 = x.e2; exUse1 = x.eu1; exUse2 = x.eu2;
    exRd = x.erd; exWrite = x.ew; exIsLoad = x.el;
    memValid = x.mv; memRd = x.mrd; memWrite = x.mw;
    wbValid = x.wv; wbRd = x.wrd; wbWrite = x.ww;
  endtask

  // Driver: one vector per cycle, expected outputs pushed to the scoreboard.
  task automatic apply(input vec_t x, input logic [1:0] a, input logic [1:0] b,
                       input logic st, input string req);
    exp_t e;
    @(posedge clk); #1;
    drive(x);
    e.a = a; e.b = b; e.st = st; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compares at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (fwdSelA !== e.a || fwdSelB !== e.b || stallFetch !== e.st || bubbleEx !== e.st) begin
        failures++;
        $display("FAIL %s: got selA=%b selB=%b stall=%b bubble=%b, expected selA=%b selB=%b stall=%b bubble=%b",
                 e.req, fwdSelA, fwdSelB, stallFetch, bubbleEx, e.a, e.b, e.st, e.st);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    drive(idleVec(2'b10));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state: forwarding captured during reset, idle outputs quiet
    apply(idleVec(2'b10), 2'b00, 2'b00, 1'b0, "R10 reset");

    // R1: memory-stage forward on operand A
    v = idleVec(2'b10); v.ev = 1; v.e1 = 5; v.eu1 = 1; v.mv = 1; v.mrd = 5; v.mw = 1;
    apply(v, 2'b01, 2'b00, 1'b0, "R1");
    // R2: writeback forward on operand B
    v = idleVec(2'b10); v.ev = 1; v.e2 = 7; v.eu2 = 1; v.wv = 1; v.wrd = 7; v.ww = 1;
    apply(v, 2'b00, 2'b10, 1'b0, "R2");
    // R3: both stages match, memory wins on both operands
    v = idleVec(2'b10); v.ev = 1; v.e1 = 9; v.e2 = 9; v.eu1 = 1; v.eu2 = 1;
    v.mv = 1; v.mrd = 9; v.mw = 1; v.wv = 1; v.wrd = 9; v.ww = 1;
    apply(v, 2'b01, 2'b01, 1'b0, "R3");
    // R4: x0 neither forwards nor stalls behind a load
    v = idleVec(2'b10); v.ev = 1; v.e1 = 0; v.eu1 = 1; v.erd = 0; v.ew = 1; v.el = 1;
    v.mv = 1; v.mrd = 0; v.mw = 1; v.dv = 1; v.d1 = 0; v.du1 = 1;
    apply(v, 2'b00, 2'b00, 1'b0, "R4");
    // R5: unused sources ignored for forwarding and load-use
    v = idleVec(2'b10); v.ev = 1; v.e1 = 6; v.eu1 = 0; v.erd = 11; v.ew = 1; v.el = 1;
    v.mv = 1; v.mrd = 6; v.mw = 1; v.dv = 1; v.d2 = 11; v.du2 = 0;
    apply(v, 2'b00, 2'b00, 1'b0, "R5");
    // R6: load-use sequence, one hold then writeback forward
    v = idleVec(2'b10); v.dv = 1; v.d1 = 3; v.du1 = 1; v.ev = 1; v.erd = 3; v.ew = 1; v.el = 1;
    apply(v, 2'b00, 2'b00, 1'b1, "R6 load-use hold");
    v = idleVec(2'b10); v.dv = 1; v.d1 = 3; v.du1 = 1; v.mv = 1; v.mrd = 3; v.mw = 1;
    apply(v, 2'b00, 2'b00, 1'b0, "R6 released");
    v = idleVec(2'b10); v.ev = 1; v.e1 = 3; v.eu1 = 1; v.wv = 1; v.wrd = 3; v.ww = 1;
    apply(v, 2'b10, 2'b00, 1'b0, "R6 wb forward");
    // R6: non-load producer needs no hold
    v = idleVec(2'b10); v.dv = 1; v.d2 = 4; v.du2 = 1; v.ev = 1; v.erd = 4; v.ew = 1;
    apply(v, 2'b00, 2'b00, 1'b0, "R6 alu producer");
    // R11: invalid memory stage and non-writing writeback ignored
    v = idleVec(2'b10); v.ev = 1; v.e1 = 8; v.e2 = 10; v.eu1 = 1; v.eu2 = 1;
    v.mv = 0; v.mrd = 8; v.mw = 1; v.wv = 1; v.wrd = 10; v.ww = 0;
    apply(v, 2'b00, 2'b00, 1'b0, "R11");

    // R10: mode change while busy has no effect
    v = idleVec(2'b00); v.ev = 1; v.e1 = 5; v.eu1 = 1; v.mv = 1; v.mrd = 5; v.mw = 1;
    apply(v, 2'b01, 2'b00, 1'b0, "R10 busy change");
    apply(v, 2'b01, 2'b00, 1'b0, "R10 still forwarding");
    // idle cycle captures interlock
    apply(idleVec(2'b01), 2'b00, 2'b00, 1'b0, "R10 idle capture");

    // R7: adjacent consumer held two cycles, selects stay register
    v = idleVec(2'b01); v.dv = 1; v.d1 = 6; v.du1 = 1; v.ev = 1; v.erd = 6; v.ew = 1;
    v.e1 = 8; v.eu1 = 1; v.mv = 1; v.mrd = 8; v.mw = 1;
    apply(v, 2'b00, 2'b00, 1'b1, "R7 adjacent cycle 1");
    v = idleVec(2'b01); v.dv = 1; v.d1 = 6; v.du1 = 1; v.mv = 1; v.mrd = 6; v.mw = 1;
    apply(v, 2'b00, 2'b00, 1'b1, "R7 adjacent cycle 2");
    v = idleVec(2'b01); v.dv = 1; v.d1 = 6; v.du1 = 1; v.wv = 1; v.wrd = 6; v.ww = 1;
    apply(v, 2'b00, 2'b00, 1'b0, "R8 writeback only");
    // R7: consumer two slots behind held one cycle
    v = idleVec(2'b01); v.dv = 1; v.d2 = 2; v.du2 = 1; v.ev = 1; v.erd = 13; v.ew = 1;
    v.mv = 1; v.mrd = 2; v.mw = 1;
    apply(v, 2'b00, 2'b00, 1'b1, "R7 distance two");
    v = idleVec(2'b01); v.dv = 1; v.d2 = 2; v.du2 = 1; v.wv = 1; v.wrd = 2; v.ww = 1;
    apply(v, 2'b00, 2'b00, 1'b0, "R8 distance two released");
    // R11: non-writing execute instruction ignored
    v = idleVec(2'b01); v.dv = 1; v.d1 = 12; v.du1 = 1; v.ev = 1; v.erd = 12; v.ew = 0;
    apply(v, 2'b00, 2'b00, 1'b0, "R11 no write");

    // R12: reserved code acts as interlock
    apply(idleVec(2'b11), 2'b00, 2'b00, 1'b0, "R12 idle capture");
    v = idleVec(2'b11); v.dv = 1; v.d1 = 14; v.du1 = 1; v.ev = 1; v.erd = 14; v.ew = 1;
    apply(v, 2'b00, 2'b00, 1'b1, "R12");

    // R9: no protection
    apply(idleVec(2'b00), 2'b00, 2'b00, 1'b0, "R9 idle capture");
    v = idleVec(2'b00); v.dv = 1; v.d1 = 15; v.du1 = 1; v.ev = 1; v.erd = 15; v.ew = 1; v.el = 1;
    v.e1 = 16; v.eu1 = 1; v.e2 = 17; v.eu2 = 1; v.mv = 1; v.mrd = 16; v.mw = 1;
    v.wv = 1; v.wrd = 17; v.ww = 1;
    apply(v, 2'b00, 2'b00, 1'b0, "R9");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule